// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Prediction

This unit sits in the fetch stage and is consulted every cycle with the address being fetched. It is a direct-mapped table. Each slot keeps a valid flag, an address tag, a stored branch destination and a two-bit saturating confidence counter. When the lookup finds a matching slot whose counter leans toward taken, the stored destination is put out as the next fetch address in the same cycle, so a correctly predicted taken branch costs no fetch bubble. In every other case the next fetch address is the current address plus four.

Later in the pipeline, when a branch is resolved, the resolve port receives four values: the branch address, the real outcome, the real destination and the direction that was predicted for it. The unit then trains the matching slot, or claims a slot for a taken branch it did not know about. When the real direction differs from the predicted one, it raises a flush request together with the address from which fetch must restart. The flush itself and instruction decoding belong to other blocks.

Top module: `btb_predictor`

## Requirements
- R1: The slot is selected by address bits [IDX_W+1:2] and the tag is bits [ADDR_W-1:IDX_W+2], with bits [1:0] ignored. A lookup hits only when the selected slot is valid and its tag matches, so two branches that share a slot but differ in tag replace each other.
- R2: On a hit whose counter is 10 or 11, `pred_taken` is 1 and `pred_next_pc` equals the stored destination in that same cycle.
- R3: On a miss, or on a hit whose counter is 00 or 01, `pred_taken` is 0 and `pred_next_pc` equals `fetch_pc + 4`. `pred_hit` reports whether a valid slot with a matching tag was found.
- R4: The counter encodings are 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. A resolved branch that hits adds one to the counter if it was taken and subtracts one if it was not, saturating at 11 and 00.
- R5: A taken branch that misses claims its slot with valid set, its tag, its destination and the counter at 10. A not-taken branch that misses changes nothing.
- R6: `flush` is 1 exactly when `res_valid` is 1 and `res_taken` differs from `res_pred_taken`. While it is 1, `flush_pc` equals `res_target` if the branch was taken and `res_pc + 4` otherwise.
- R7: When a lookup and an update address the same slot in one cycle, the lookup returns the slot's contents from before the update.
- R8: Reset clears every valid flag, so every lookup misses until branches are trained. Reset is applied asynchronously and released on a clock edge.
- R9: With the counter hysteresis, the exit branch of a loop that runs several times mispredicts only once per pass through the loop, after the first pass has trained it.
- R10: A taken branch that hits overwrites the stored destination with the resolved one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| pred_taken | output | 1 | Lookup predicts a taken branch |
| pred_hit | output | 1 | Lookup found a valid slot with a matching tag |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_target | input | ADDR_W | Real destination of the resolved branch |
| res_pred_taken | input | 1 | Direction that was predicted for this branch |
| flush | output | 1 | Misprediction: the pipeline must be flushed |
| flush_pc | output | ADDR_W | Address from which fetch restarts |

## Verification
A corrupted counter shows up at the ports on the very next lookup of that branch, as a wrong `pred_taken` and a wrong `pred_next_pc`. A bad tag or valid flag shows up as a false hit, or as a lost hit after an aliasing branch was trained. A stored destination that is wrong only appears once the counter leans toward taken, so the bench trains every slot through all counter paths and looks the slot up in the cycle after every update. The loop scenario takes its predicted direction from the unit's own output, so a fault in the hysteresis changes how many flushes are counted in the second pass.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;
endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr
  import btb_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  output ctr_e nxt
);
  always_comb begin
    nxt = cur;
    if (taken && cur != CTR_ST)       nxt = ctr_e'(cur + 2'd1);
    else if (!taken && cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
  end
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W   = ADDR_W - IDX_W - 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output ctr_e              lk_ctr,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  ctr_e               ctr_q [ENTRIES];

  logic [ENTRIES-1:0] train_en;
  logic [ENTRIES-1:0] alloc_en;
  logic               upd_hit;
  ctr_e               upd_cur;
  ctr_e               upd_nxt;

  // lookup reads registered state only: same-cycle update is not seen
  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_ctr    = ctr_q[lk_idx];
  assign lk_target = tgt_q[lk_idx];

  assign upd_hit = valid_q[upd_idx] && (tag_q[upd_idx] == upd_tag);
  assign upd_cur = ctr_q[upd_idx];

  btb_sat_ctr u_ctr (
    .cur   (upd_cur),
    .taken (upd_taken),
    .nxt   (upd_nxt)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot_en
    logic sel;
    assign sel         = upd_en && (upd_idx == IDX_W'(g));
    assign train_en[g] = sel && upd_hit;
    assign alloc_en[g] = sel && !upd_hit && upd_taken;
  end

  always_comb begin
    valid_d = valid_q | alloc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_en[i]) begin
        tag_q[i] <= upd_tag;
        tgt_q[i] <= upd_target;
        ctr_q[i] <= CTR_WT;
      end else if (train_en[i]) begin
        ctr_q[i] <= upd_nxt;
        if (upd_taken) tgt_q[i] <= upd_target;
      end
    end
  end

  // R5: any taken resolve leaves a matching valid slot with its destination
  assert_taken_installs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken) |=> (valid_q[$past(upd_idx)] &&
                               tag_q[$past(upd_idx)] == $past(upd_tag) &&
                               tgt_q[$past(upd_idx)] == $past(upd_target)));

  assert_nt_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && !upd_hit) |=> (valid_q == $past(valid_q)));

  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_hit && upd_taken && upd_cur == CTR_ST) |=> (ctr_q[$past(upd_idx)] == CTR_ST));

  assert_sat_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_hit && !upd_taken && upd_cur == CTR_SNT) |=> (ctr_q[$past(upd_idx)] == CTR_SNT));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_taken,
  output logic              pred_hit,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_pred_taken,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic              rst_sync_n;
  logic              lk_hit;
  ctr_e              lk_ctr;
  logic [ADDR_W-1:0] lk_target;

  btb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lk_idx     (fetch_pc[TAG_LO-1:IDX_LO]),
    .lk_tag     (fetch_pc[ADDR_W-1:TAG_LO]),
    .lk_hit     (lk_hit),
    .lk_ctr     (lk_ctr),
    .lk_target  (lk_target),
    .upd_en     (res_valid),
    .upd_idx    (res_pc[TAG_LO-1:IDX_LO]),
    .upd_tag    (res_pc[ADDR_W-1:TAG_LO]),
    .upd_taken  (res_taken),
    .upd_target (res_target)
  );

  always_comb begin
    pred_hit     = lk_hit;
    pred_taken   = lk_hit && lk_ctr[1];
    pred_next_pc = pred_taken ? lk_target : fetch_pc + ADDR_W'(4);
  end

  always_comb begin
    flush    = res_valid && (res_taken != res_pred_taken);
    flush_pc = res_taken ? res_target : res_pc + ADDR_W'(4);
  end

  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pred_taken |-> (pred_next_pc == fetch_pc + ADDR_W'(4)));

  assert_taken_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pred_taken |-> pred_hit);

  assert_flush_needs_resolve_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |-> res_valid);
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 2;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] fetch_pc, pred_next_pc, res_pc, res_target, flush_pc;
  logic          pred_taken, pred_hit, res_valid, res_taken, res_pred_taken, flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side expectation of each slot
  bit          m_v   [NE];
  logic [11:0] m_tag [NE];
  logic [AW-1:0] m_tgt [NE];
  int          m_ctr [NE];
  bit          last_flush;
  bit          last_ptk;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
    .pred_taken(pred_taken), .pred_hit(pred_hit), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_pred_taken(res_pred_taken),
    .flush(flush), .flush_pc(flush_pc)
  );

  task automatic chk(input bit ok, input string tag, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 0; fetch_pc = '0; res_pc = '0;
    res_taken = 0; res_target = '0; res_pred_taken = 0;
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one cycle: drive, compare combinational outputs, then advance the expectation
  task automatic step(input [AW-1:0] fpc, input bit rv, input [AW-1:0] rpc,
                      input bit rtk, input [AW-1:0] rtg, input bit rpd, input string tag);
    int fi, ri;
    bit eh, ept, rh, ef;
    logic [AW-1:0] enp, efp;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk;
    res_target = rtg; res_pred_taken = rpd;
    #1;
    fi  = int'(fpc[3:2]);
    eh  = m_v[fi] && (m_tag[fi] == fpc[15:4]);
    ept = eh && (m_ctr[fi] >= 2);
    enp = ept ? m_tgt[fi] : fpc + 16'd4;
    chk(pred_hit == eh, {tag, " R1 hit"}, pred_hit, eh);
    chk(pred_taken == ept, {tag, " R2 taken"}, pred_taken, ept);
    chk(pred_next_pc == enp, {tag, " R3 next"}, pred_next_pc, enp);
    ef  = rv && (rtk != rpd);
    efp = rtk ? rtg : rpc + 16'd4;
    chk(flush == ef, {tag, " R6 flush"}, flush, ef);
    if (ef) chk(flush_pc == efp, {tag, " R6 flush_pc"}, flush_pc, efp);
    last_flush = flush;
    last_ptk   = pred_taken;
    if (rv) begin
      ri = int'(rpc[3:2]);
      rh = m_v[ri] && (m_tag[ri] == rpc[15:4]);
      if (rh) begin
        if (rtk) begin
          m_ctr[ri] = (m_ctr[ri] == 3) ? 3 : m_ctr[ri] + 1;
          m_tgt[ri] = rtg;
        end else begin
          m_ctr[ri] = (m_ctr[ri] == 0) ? 0 : m_ctr[ri] - 1;
        end
      end else if (rtk) begin
        m_v[ri] = 1; m_tag[ri] = rpc[15:4]; m_tgt[ri] = rtg; m_ctr[ri] = 2;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R8: all slots miss after reset, several tags per slot
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < NE; i++)
        step(16'(t * 16'h0100 + i * 4), 0, '0, 0, '0, 0, "R8 reset");

    // R4 / R7 / R10: every slot, every 4-outcome pattern; lookup aims at the slot being updated
    for (int i = 0; i < NE; i++)
      for (int p = 0; p < 16; p++)
        for (int b = 0; b < 4; b++) begin
          logic [AW-1:0] bpc;
          bpc = 16'h1200 + 16'(i * 4);
          step(bpc, 1, bpc, p[b], 16'(16'h3000 + p * 16 + b * 4), b[0], "R4 R7 sweep");
        end
    // look each slot up once more to expose the last update (R10 destination)
    for (int i = 0; i < NE; i++)
      step(16'h1200 + 16'(i * 4), 0, '0, 0, '0, 0, "R10 after");

    // R5: not-taken miss allocates nothing, then taken miss allocates weakly taken
    step(16'h0000, 1, 16'h5504, 0, 16'h7777, 1, "R5 nt miss");
    step(16'h5504, 0, '0, 0, '0, 0, "R5 nt miss");
    step(16'h0000, 1, 16'h5504, 1, 16'h6660, 0, "R5 t miss");
    step(16'h5504, 0, '0, 0, '0, 0, "R5 t alloc");

    // R1: aliasing tag replaces the slot; the old branch then misses; low pc bits ignored
    step(16'h0000, 1, 16'h9904, 1, 16'h4440, 0, "R1 alias");
    step(16'h5504, 0, '0, 0, '0, 0, "R1 old miss");
    step(16'h9905, 0, '0, 0, '0, 0, "R1 low bits");
    step(16'h9907, 0, '0, 0, '0, 0, "R1 low bits");

    // R9: loop exit branch, direction fed back from the unit's own prediction
    do_reset();
    for (int run = 0; run < 2; run++) begin
      int nflush;
      nflush = 0;
      for (int it = 0; it < 4; it++) begin
        bit p;
        step(16'h0040, 0, '0, 0, '0, 0, "R9 fetch");
        p = last_ptk;
        if (run == 1 && it == 0) chk(p == 1, "R9 kept taken", p, 1);
        step(16'h0000, 1, 16'h0040, it < 3, 16'h0020, p, "R9 resolve");
        if (last_flush) nflush++;
      end
      if (run == 1) chk(nflush == 1, "R9 flush count", nflush, 1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule